// File: doc/BRIEF.md
# Multichannel Switchable DC-Blocking Filter

This block strips the DC component from a stream of signed audio samples. Several channels share one arithmetic datapath. Each incoming sample carries a channel tag and a valid strobe. The block keeps a separate history for every channel: the previous input and the previous output. The filter is first-order: y[n] = x[n] - x[n-1] + a*y[n-1].

The coefficient is fixed at a = 1 - 2^-13, about 0.999878. This places the -3 dB corner just below 2 Hz at a 96 kHz sample rate. The multiply therefore reduces to one arithmetic shift and one subtract. The result saturates to the sample word range and never wraps.

A single enable input selects filtering or exact pass-through. Both paths have the same one-cycle latency. Turning the filter back on wipes the history of every channel, so stale state never leaks into the output. Out of reset the history is zero and the block treats the filter as already enabled.

Top module: `dcb_hpf_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_valid is 0 and out_sample is 0. Every channel's history is zero, so the first filtered sample of any channel after reset equals its input.
- R2: With hpf_en=1, a sample x on channel c yields y = clamp(x - xp + yp - (yp >>> 13)). Here xp and yp are channel c's previous input and output, and >>> is an arithmetic right shift. After the sample, xp becomes x and yp becomes y.
- R3: A sample on channel c reads and updates only channel c's history. Samples on other channels in between do not change channel c's results.
- R4: With hpf_en=0, out_sample equals in_sample bit for bit.
- R5: out_valid is 1 exactly one cycle after in_valid is 1, and 0 otherwise. In that cycle out_ch equals the tag that came with the sample. This holds for both the filtered and the bypass path.
- R6: In a cycle where hpf_en is 1 and it was 0 in the previous cycle, every channel's history is cleared. A sample presented in that same cycle is filtered against zero history, so its output equals its input.
- R7: A result above 2^23-1 is output as 2^23-1. A result below -2^23 is output as -2^23 (24-bit two's-complement samples).
- R8: For a constant input on a channel, each filtered output after the first has a magnitude no larger than the one before it.
- R9: When in_valid is 0, out_sample keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hpf_en | input | 1 | 1 = filter, 0 = pass-through |
| in_valid | input | 1 | Input sample strobe |
| in_ch | input | 3 | Channel tag of the input sample |
| in_sample | input | 24 | Signed input sample |
| out_valid | output | 1 | Output sample strobe |
| out_ch | output | 3 | Channel tag of the output sample |
| out_sample | output | 24 | Signed filtered or bypassed sample |

## Verification
The clear of all channel histories on a rising enable can land in the same cycle as a valid sample. That sample's channel is both cleared and written, so the write must win and must use zero history. The bench provokes this by ending a bypass run and presenting a sample in the very cycle the enable returns to 1. It expects an output equal to the input. It then checks that every other channel also restarts from zero, by comparing against a reference model whose history was wiped at that point. A separate sweep pairs saturation with back-to-back samples across channels.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
    localparam int SAMPLE_W   = 24;
    localparam int NUM_CH     = 8;
    localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int COEF_SHIFT = 13;
    localparam int ACC_W      = SAMPLE_W + 2;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic [CH_W-1:0]            chan_t;
    typedef logic signed [ACC_W-1:0]    acc_t;

    // per-channel filter history
    typedef struct packed {
        sample_t x_prev;
        sample_t y_prev;
    } hist_t;

    // one tagged sample beat
    typedef struct packed {
        logic    valid;
        chan_t   ch;
        sample_t data;
    } beat_t;

    localparam sample_t SAMPLE_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};
    localparam sample_t SAMPLE_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};

    function automatic sample_t clamp(input acc_t v);
        if (v > acc_t'(SAMPLE_MAX))
            return SAMPLE_MAX;
        else if (v < acc_t'(SAMPLE_MIN))
            return SAMPLE_MIN;
        else
            return sample_t'(v);
    endfunction
endpackage

// File: rtl/dcb_hist_bank.sv
module dcb_hist_bank
    import dcb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr_all,
    input  logic  wr_en,
    input  chan_t wr_ch,
    input  hist_t wr_data,
    input  chan_t rd_ch,
    output hist_t rd_data
);
    hist_t bank [NUM_CH];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_entry
        hist_t q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (wr_en && wr_ch == chan_t'(i))
                q <= wr_data;
            else if (clr_all)
                q <= '0;
        end
        assign bank[i] = q;
    end

    assign rd_data = bank[rd_ch];
endmodule

// File: rtl/dcb_core.sv
module dcb_core
    import dcb_pkg::*;
(
    input  sample_t x,
    input  hist_t   h,
    output sample_t y
);
    acc_t diff, leak, sum;

    always_comb begin
        diff = acc_t'(x) - acc_t'(h.x_prev);
        leak = acc_t'(h.y_prev) - (acc_t'(h.y_prev) >>> COEF_SHIFT);
        sum  = diff + leak;
        y    = clamp(sum);
    end
endmodule

// File: rtl/dcb_hpf_top.sv
module dcb_hpf_top
    import dcb_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       hpf_en,
    input  logic                       in_valid,
    input  logic [CH_W-1:0]            in_ch,
    input  logic signed [SAMPLE_W-1:0] in_sample,
    output logic                       out_valid,
    output logic [CH_W-1:0]            out_ch,
    output logic signed [SAMPLE_W-1:0] out_sample
);
    beat_t   in_beat;
    beat_t   out_q;
    logic    en_prev;
    logic    en_rise;
    hist_t   hist_rd;
    hist_t   hist_use;
    hist_t   hist_wr;
    sample_t y_filt;
    sample_t y_sel;

    assign in_beat = '{valid: in_valid, ch: in_ch, data: in_sample};

    // previous enable; reset value marks the filter as already on
    always_ff @(posedge clk) begin
        if (rst)
            en_prev <= 1'b1;
        else
            en_prev <= hpf_en;
    end

    assign en_rise  = hpf_en && !en_prev;
    assign hist_use = en_rise ? '0 : hist_rd;

    dcb_hist_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .clr_all (en_rise),
        .wr_en   (in_beat.valid && hpf_en),
        .wr_ch   (in_beat.ch),
        .wr_data (hist_wr),
        .rd_ch   (in_beat.ch),
        .rd_data (hist_rd)
    );

    dcb_core u_core (
        .x (in_beat.data),
        .h (hist_use),
        .y (y_filt)
    );

    assign hist_wr = '{x_prev: in_beat.data, y_prev: y_filt};
    assign y_sel   = hpf_en ? y_filt : in_beat.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.valid <= in_beat.valid;
            if (in_beat.valid) begin
                out_q.ch   <= in_beat.ch;
                out_q.data <= y_sel;
            end
        end
    end

    assign out_valid  = out_q.valid;
    assign out_ch     = out_q.ch;
    assign out_sample = out_q.data;
endmodule

// File: rtl/dcb_hpf_chk.sv
module dcb_hpf_chk
    import dcb_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic                       hpf_en,
    input logic                       in_valid,
    input logic [CH_W-1:0]            in_ch,
    input logic signed [SAMPLE_W-1:0] in_sample,
    input logic                       out_valid,
    input logic [CH_W-1:0]            out_ch,
    input logic signed [SAMPLE_W-1:0] out_sample
);
    // R1
    reset_out_chk: assert property (@(posedge clk) rst |=> (!out_valid && out_sample == '0));

    // R5
    valid_lat_chk: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);

    // R5
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid);

    // R5
    tag_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_ch == $past(in_ch));

    // R4
    bypass_exact_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !hpf_en) |=> out_sample == $past(in_sample));

    // R6
    rise_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && hpf_en && !$past(hpf_en)) |=> out_sample == $past(in_sample));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_sample));
endmodule

bind dcb_hpf_top dcb_hpf_chk u_chk (.*);

// File: tb/sim_dcb_hpf_top.sv
module sim_dcb_hpf_top;
    import dcb_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hpf_en = 1'b1;
    logic in_valid = 1'b0;
    logic [CH_W-1:0] in_ch = '0;
    logic signed [SAMPLE_W-1:0] in_sample = '0;
    logic out_valid;
    logic [CH_W-1:0] out_ch;
    logic signed [SAMPLE_W-1:0] out_sample;

    int n_chk = 0;
    int n_fail = 0;
    longint xp_m [NUM_CH];
    longint yp_m [NUM_CH];
    logic en_m = 1'b1;
    longint last_y = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dcb_hpf_top u0 (.*);

    localparam longint VMAX = (longint'(1) <<< (SAMPLE_W-1)) - 1;
    localparam longint VMIN = -(longint'(1) <<< (SAMPLE_W-1));

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint sat(input longint v);
        if (v > VMAX) return VMAX;
        if (v < VMIN) return VMIN;
        return v;
    endfunction

    function automatic void clear_model();
        for (int i = 0; i < NUM_CH; i++) begin
            xp_m[i] = 0;
            yp_m[i] = 0;
        end
    endfunction

    // present one sample, check it one cycle later, return expected output
    task automatic send(input int ch, input longint x, input logic en, input string tag);
        longint exp_y;
        in_valid  = 1'b1;
        in_ch     = CH_W'(ch);
        in_sample = SAMPLE_W'(x);
        hpf_en    = en;
        if (en && !en_m) clear_model();
        if (en) begin
            exp_y = sat(x - xp_m[ch] + yp_m[ch] - (yp_m[ch] >>> COEF_SHIFT));
            xp_m[ch] = x;
            yp_m[ch] = exp_y;
        end else begin
            exp_y = x;
        end
        en_m = en;
        @(negedge clk);
        check(out_valid == 1'b1, "R5 valid", longint'(out_valid), 1);
        check(out_ch == CH_W'(ch), "R5 tag", longint'(out_ch), ch);
        check(longint'(out_sample) == exp_y, tag, longint'(out_sample), exp_y);
        last_y = longint'(out_sample);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        longint lcg;
        longint prev_mag;
        clear_model();
        repeat (3) @(negedge clk);
        // R1 reset state
        check(out_valid == 1'b0, "R1 valid in reset", longint'(out_valid), 0);
        check(out_sample == '0, "R1 sample in reset", longint'(out_sample), 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 valid after reset", longint'(out_valid), 0);

        // R1 first sample per channel equals input
        for (int c = 0; c < NUM_CH; c++)
            send(c, 1000 * (c + 1) - 3000, 1'b1, "R1 first sample");

        // R2/R3 ramps interleaved across channels
        for (int r = 0; r < 16; r++)
            for (int c = 0; c < NUM_CH; c++)
                send(c, (r * 37 + c * 1111) * (c[0] ? -1 : 1), 1'b1, "R2 ramp");

        // R3 long run on one channel, then others resume
        for (int r = 0; r < 20; r++) send(3, 50000 - r * 4000, 1'b1, "R3 single channel");
        for (int c = 0; c < NUM_CH; c++) send(c, 7, 1'b1, "R3 resume");

        // R8 DC decay on channels 0 and 5
        clear_model();
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        send(0, 3000000, 1'b1, "R8 dc first");
        prev_mag = (last_y < 0) ? -last_y : last_y;
        for (int r = 0; r < 40; r++) begin
            send(0, 3000000, 1'b1, "R8 dc");
            check(((last_y < 0) ? -last_y : last_y) <= prev_mag, "R8 decay",
                  (last_y < 0) ? -last_y : last_y, prev_mag);
            prev_mag = (last_y < 0) ? -last_y : last_y;
            send(5, -2500000, 1'b1, "R8 dc neg");
        end

        // R9 hold with idle cycles
        idle(3);
        check(longint'(out_sample) == last_y, "R9 hold", longint'(out_sample), last_y);
        check(out_valid == 1'b0, "R5 idle valid", longint'(out_valid), 0);

        // R7 saturation sweeps
        for (int c = 0; c < NUM_CH; c++) begin
            send(c, VMIN, 1'b1, "R7 low setup");
            send(c, VMAX, 1'b1, "R7 high clamp");
            send(c, VMIN, 1'b1, "R7 low clamp");
        end

        // R4 bypass with pseudo-random data
        lcg = 12345;
        for (int r = 0; r < 64; r++) begin
            lcg = (lcg * 1103515245 + 12345) & 64'hFFFFFF;
            send(r % NUM_CH, lcg - (longint'(1) <<< (SAMPLE_W-1)), 1'b0, "R4 bypass");
        end

        // R6 enable rises together with a sample; all channels restart
        send(2, 123456, 1'b1, "R6 rise same cycle");
        for (int c = 0; c < NUM_CH; c++) send(c, -4321 + c, 1'b1, "R6 after clear");

        // R6 rise on an idle cycle, then samples
        send(1, 99, 1'b0, "R4 bypass");
        in_valid = 1'b0;
        hpf_en = 1'b1;
        clear_model();
        en_m = 1'b1;
        @(negedge clk);
        for (int c = 0; c < NUM_CH; c++) send(c, 5555 * c, 1'b1, "R6 idle rise");

        // R2 random mixed stream, random channel order
        for (int r = 0; r < 600; r++) begin
            lcg = (lcg * 1103515245 + 12345) & 64'hFFFFFF;
            send(int'(lcg % NUM_CH), lcg - (longint'(1) <<< (SAMPLE_W-1)), 1'b1, "R2 random");
            if (r % 50 == 49) idle(1);
        end
        idle(2);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule